// File: doc/BRIEF.md
# Bus-Multiplexed Up/Down Binary Counter

This block is a synchronous binary counter that reads its load value from a shared bidirectional data port and shows its state on that same port. A two-bit mode input chooses among parallel load, count up, count down and hold. Every state change happens on the rising clock edge. There is no reset of any kind, so the first operation after power-up should be a load.

An active-low count enable gates counting. An active-low terminal-count output tells the next stage that this stage is about to carry or borrow. Wiring one stage's terminal count into the next stage's count enable therefore builds a wider counter. An active-low output enable chooses who owns the port. When it is low the counter drives the port. When it is high the port is released and serves as the load input.

The tri-state port is split into three signals so that the block can be synthesized: an input bus, an output bus and a drive enable. The output bus always carries the register, and the drive enable says whether it is placed on the wires.

Top module: `bus_updown_counter`

## Requirements
- R1: The mode input is encoded as follows: 00 = load, 10 = count up, 01 = count down, 11 = hold. Bit 1 is the first select and bit 0 is the second. In load mode with out_en_n high, a rising edge copies bus_in into the register.
- R2: In mode 10 with cnt_en_n low, the register increments by one on each rising edge.
- R3: In mode 01 with cnt_en_n low, the register decrements by one on each rising edge.
- R4: In mode 10 or 01 with cnt_en_n high, the register holds its value and term_n is high.
- R5: In mode 11 the register holds its value and term_n is high, whatever the level of cnt_en_n.
- R6: bus_drv equals the inverse of out_en_n. bus_out always carries the register contents.
- R7: term_n is low only when cnt_en_n is low and either the mode is 10 with the register at its maximum, or the mode is 01 with the register at zero. In every other case, including load mode, term_n is high.
- R8: Counting wraps modulo 2^WIDTH: up from the maximum value gives zero, and down from zero gives the maximum value.
- R9: A load requested while out_en_n is low has no effect: the register keeps its value.
- R10: When two stages are cascaded, with the low stage's term_n driving the high stage's cnt_en_n, the pair counts up and down as one 2*WIDTH-bit counter, carries and borrows included.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| mode_sel | input | 2 | Operation select (00 load, 10 up, 01 down, 11 hold) |
| cnt_en_n | input | 1 | Active-low count enable |
| out_en_n | input | 1 | Active-low port drive enable |
| bus_in | input | WIDTH | Value sensed on the shared port |
| bus_out | output | WIDTH | Register value presented to the shared port |
| bus_drv | output | 1 | High when the port is driven by the counter |
| term_n | output | 1 | Active-low terminal count for cascading |

## Verification
A corrupted register appears on bus_out at the sample point right after the edge that corrupted it, because the output bus mirrors the flip-flops with no further stage. A fault in the terminal-count decode shows up in the same cycle as a wrong term_n. In a cascade it also shows up one edge later, because the high stage then fails to step or steps when it should not. The bench therefore compares every cycle of long up and down runs of a two-stage chain against a 16-bit reference, so a fault appears at most one edge after it occurs.

// File: rtl/bus_updown_counter.sv
module bus_updown_counter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic [1:0]       mode_sel,
  input  logic             cnt_en_n,
  input  logic             out_en_n,
  input  logic [WIDTH-1:0] bus_in,
  output logic [WIDTH-1:0] bus_out,
  output logic             bus_drv,
  output logic             term_n
);

  localparam logic [1:0] MODE_LOAD = 2'b00;
  localparam logic [1:0] MODE_UP   = 2'b10;
  localparam logic [1:0] MODE_DOWN = 2'b01;
  localparam logic [WIDTH-1:0] ALL_ONES = '1;
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] cnt_q;
  logic do_load, do_up, do_down;

  assign do_load = (mode_sel == MODE_LOAD) && out_en_n;
  assign do_up   = (mode_sel == MODE_UP)   && !cnt_en_n;
  assign do_down = (mode_sel == MODE_DOWN) && !cnt_en_n;

  always_ff @(posedge clk) begin
    if (do_load)      cnt_q <= bus_in;
    else if (do_up)   cnt_q <= cnt_q + ONE;
    else if (do_down) cnt_q <= cnt_q - ONE;
  end

  assign bus_out = cnt_q;
  assign bus_drv = !out_en_n;
  assign term_n  = !((do_up && cnt_q == ALL_ONES) || (do_down && cnt_q == '0));

  assert_load_R1: assert property (@(posedge clk) disable iff ($isunknown(bus_in))
    (mode_sel == MODE_LOAD && out_en_n) |=> (cnt_q == $past(bus_in)));

  assert_up_step_R2: assert property (@(posedge clk) disable iff ($isunknown(cnt_q))
    (mode_sel == MODE_UP && !cnt_en_n) |=> (cnt_q == $past(cnt_q) + ONE));

  assert_down_step_R3: assert property (@(posedge clk) disable iff ($isunknown(cnt_q))
    (mode_sel == MODE_DOWN && !cnt_en_n) |=> (cnt_q == $past(cnt_q) - ONE));

  assert_gated_hold_R4: assert property (@(posedge clk) disable iff ($isunknown(cnt_q))
    (mode_sel[0] != mode_sel[1] && cnt_en_n) |=> $stable(cnt_q));

  assert_gated_tc_R4: assert property (@(posedge clk) disable iff ($isunknown(cnt_q))
    (mode_sel[0] != mode_sel[1] && cnt_en_n) |-> term_n);

  assert_hold_mode_R5: assert property (@(posedge clk) disable iff ($isunknown(cnt_q))
    (mode_sel == 2'b11) |=> $stable(cnt_q));

  assert_tc_wrap_R8: assert property (@(posedge clk) disable iff ($isunknown(cnt_q))
    (!term_n && mode_sel == MODE_UP) |=> (cnt_q == '0));

  assert_tc_load_R7: assert property (@(posedge clk) disable iff ($isunknown(cnt_q))
    (mode_sel == MODE_LOAD) |-> term_n);

  assert_bad_load_R9: assert property (@(posedge clk) disable iff ($isunknown(cnt_q))
    (mode_sel == MODE_LOAD && !out_en_n) |=> $stable(cnt_q));

endmodule

// File: tb/bus_updown_counter_tb.sv
module bus_updown_counter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [1:0]  mode_sel = 2'b11;
  logic        cen_n = 1'b1;
  logic        oe_n = 1'b1;
  logic [15:0] din = '0;
  logic [7:0]  lo_out, hi_out;
  logic        lo_drv, hi_drv, lo_tc_n, hi_tc_n;

  bus_updown_counter #(.WIDTH(8)) dut_i (
    .clk(clk), .mode_sel(mode_sel), .cnt_en_n(cen_n), .out_en_n(oe_n),
    .bus_in(din[7:0]), .bus_out(lo_out), .bus_drv(lo_drv), .term_n(lo_tc_n));

  bus_updown_counter #(.WIDTH(8)) dut_hi_i (
    .clk(clk), .mode_sel(mode_sel), .cnt_en_n(lo_tc_n), .out_en_n(oe_n),
    .bus_in(din[15:8]), .bus_out(hi_out), .bus_drv(hi_drv), .term_n(hi_tc_n));

  typedef struct {
    logic [15:0] val;
    logic        tc_n;
    logic        drv;
    string       tag;
  } item_t;

  item_t       sb_q[$];
  int          total = 0;
  int          bad = 0;
  logic [15:0] ref_v = '0;
  bit          done = 0;

  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      total++;
      if ({hi_out, lo_out} !== it.val) begin
        bad++;
        $display("FAIL %s value: actual=%h expected=%h", it.tag, {hi_out, lo_out}, it.val);
      end
      total++;
      if (hi_tc_n !== it.tc_n) begin
        bad++;
        $display("FAIL %s R7 term: actual=%b expected=%b", it.tag, hi_tc_n, it.tc_n);
      end
      total++;
      if (lo_drv !== it.drv || hi_drv !== it.drv) begin
        bad++;
        $display("FAIL %s R6 drive: actual=%b%b expected=%b", it.tag, hi_drv, lo_drv, it.drv);
      end
    end
  end

  task automatic step(input logic [1:0] m, input logic c, input logic o,
                      input logic [15:0] d, input string tag);
    item_t it;
    @(negedge clk);
    #2;
    mode_sel = m; cen_n = c; oe_n = o; din = d;
    if (m == 2'b00 && o) ref_v = d;
    else if (m == 2'b10 && !c) ref_v = ref_v + 16'd1;
    else if (m == 2'b01 && !c) ref_v = ref_v - 16'd1;
    it.val  = ref_v;
    it.drv  = !o;
    it.tc_n = !(!c && ((m == 2'b10 && ref_v == 16'hFFFF) || (m == 2'b01 && ref_v == 16'h0000)));
    it.tag  = tag;
    @(posedge clk);
    #1;
    sb_q.push_back(it);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(2'b00, 1'b1, 1'b1, 16'h00FE, "R1 load");
    step(2'b00, 1'b0, 1'b1, 16'hFFFF, "R1 R7 load tc high");
    step(2'b00, 1'b0, 1'b1, 16'h00FE, "R1 reload");
    for (int i = 0; i < 4; i++) step(2'b10, 1'b0, 1'b0, 16'h0, "R2 R10 up carry");
    step(2'b00, 1'b1, 1'b1, 16'hFFFD, "R1 load near top");
    for (int i = 0; i < 4; i++) step(2'b10, 1'b0, 1'b0, 16'h0, "R7 R8 up wrap");
    step(2'b00, 1'b1, 1'b1, 16'h0002, "R1 load near zero");
    for (int i = 0; i < 4; i++) step(2'b01, 1'b0, 1'b0, 16'h0, "R3 R8 down wrap");
    step(2'b00, 1'b1, 1'b1, 16'h0100, "R1 load borrow");
    step(2'b01, 1'b0, 1'b0, 16'h0, "R3 R10 down borrow");
    step(2'b10, 1'b1, 1'b0, 16'h0, "R4 up gated");
    step(2'b01, 1'b1, 1'b1, 16'h0, "R4 down gated");
    step(2'b11, 1'b0, 1'b0, 16'h0, "R5 hold en low");
    step(2'b11, 1'b1, 1'b0, 16'h0, "R5 hold en high");
    step(2'b00, 1'b0, 1'b0, 16'h1234, "R9 load while driving");
    step(2'b11, 1'b0, 1'b0, 16'h0, "R9 R6 value kept");
    step(2'b00, 1'b1, 1'b1, 16'hFF00, "R1 load long run");
    for (int i = 0; i < 600; i++) step(2'b10, 1'b0, 1'b0, 16'h0, "R10 long up");
    for (int i = 0; i < 700; i++) step(2'b01, 1'b0, 1'b0, 16'h0, "R10 long down");
    step(2'b00, 1'b1, 1'b1, 16'h0000, "R1 load zero");
    step(2'b10, 1'b1, 1'b0, 16'h0, "R4 R7 zero gated");
    step(2'b01, 1'b0, 1'b0, 16'h0, "R3 R8 zero down");
    step(2'b11, 1'b1, 1'b1, 16'h0, "R6 release");
    @(negedge clk);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule